// File: doc/BRIEF.md
# Programmable Access Delay Timer

This timer supplies the waiting intervals that an external bus sequencer needs between the phases of a memory access. The sequencer raises a start strobe with a 3-bit period code, a fast-read flag, a request type and a tick-source select. The timer then counts source ticks until the requested interval has passed. When it has, it raises `done` for one cycle so the sequencer can go on to the next phase.

There are two tick sources. One is an asynchronous oscillator input, passed through a two-flop synchronizer, where each rising edge counts as one tick. The other is an internal stand-in for a delay line: a free-running divider that produces one tick every eight system clocks. The period code expands into an 8-bit tick count, and normal mode and fast-read mode use different counts. An alignment request ignores the code and waits for exactly one tick, so an access can start in step with the tick source.

Top module: `acc_delay_timer`

## Requirements
- R1: While reset is asserted and right after it is released, `done` and `busy` are 0.
- R2: A standard request with `fast_rd`=0 lasts (code+1)×4 source ticks. Code 0 gives 4 ticks and code 7 gives 32.
- R3: A standard request with `fast_rd`=1 lasts (code+1)×2 source ticks. Code 0 gives 2 ticks and code 7 gives 16.
- R4: A request with `align_req`=1 lasts exactly one source tick, whatever the code and the fast-read flag.
- R5: `src_dl`=1 selects the internal source, which ticks once every 8 system clocks from reset onward. `src_dl`=0 selects the oscillator, which ticks once per rising edge of `osc_in`, seen two clocks late through the synchronizer.
- R6: An oscillator level held high produces no further ticks. Only a low-to-high transition counts.
- R7: A start strobe that arrives while `busy`=1 is ignored. It does not restart or lengthen the running delay.
- R8: `done` is a pulse one cycle wide. It rises on the edge that consumes the last tick, and `busy` falls on that same edge.
- R9: The code, flags and source select are captured on the accepting edge, and later changes do not affect the running delay. A tick that falls on that same edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Asynchronous oscillator tick source |
| start | input | 1 | Request strobe, accepted when idle |
| align_req | input | 1 | 1: single-tick alignment delay, 0: standard delay |
| period_code | input | 3 | Delay period code |
| fast_rd | input | 1 | Selects the fast-read count for standard delays |
| src_dl | input | 1 | Tick source: 1 internal divider, 0 oscillator |
| busy | output | 1 | Delay in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest conditions to reach from the ports are a start strobe that lands on the same edge as an internal tick, and an oscillator edge that reaches the counter exactly when the delay is accepted. The internal divider runs freely from reset, so the bench issues requests at many different idle gaps, which sweeps the start phase across all eight divider positions. For the oscillator, the bench varies the half-period while delays are running and also holds the level high for long stretches, so that rising edges fall both on the accepting edge and well clear of it.

// File: rtl/acc_delay_timer.sv
module acc_delay_timer #(
  parameter int CODE_W   = 3,
  parameter int CNT_W    = 8,
  parameter int NORM_MUL = 4,
  parameter int FAST_MUL = 2,
  parameter int DL_DIV   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_in,
  input  logic              start,
  input  logic              align_req,
  input  logic [CODE_W-1:0] period_code,
  input  logic              fast_rd,
  input  logic              src_dl,
  output logic              busy,
  output logic              done
);
  localparam int NCODE = 1 << CODE_W;
  localparam int DLW   = (DL_DIV > 1) ? $clog2(DL_DIV) : 1;

  logic [CNT_W-1:0] lut_norm [NCODE];
  logic [CNT_W-1:0] lut_fast [NCODE];

  for (genvar i = 0; i < NCODE; i++) begin : g_lut
    assign lut_norm[i] = CNT_W'((i + 1) * NORM_MUL);
    assign lut_fast[i] = CNT_W'((i + 1) * FAST_MUL);
  end

  logic [2:0] osc_sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) osc_sh <= '0;
    else        osc_sh <= {osc_sh[1:0], osc_in};

  wire osc_tick = osc_sh[1] & ~osc_sh[2];

  logic [DLW-1:0] dl_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              dl_cnt <= '0;
    else if (dl_cnt == DLW'(DL_DIV - 1))     dl_cnt <= '0;
    else                                     dl_cnt <= dl_cnt + 1'b1;

  wire dl_tick = (dl_cnt == DLW'(DL_DIV - 1));

  logic             src_q;
  logic [CNT_W-1:0] remain;
  wire              tick   = src_q ? dl_tick : osc_tick;
  wire [CNT_W-1:0]  target = align_req ? CNT_W'(1)
                           : (fast_rd ? lut_fast[period_code] : lut_norm[period_code]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      src_q  <= 1'b0;
      remain <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          src_q  <= src_dl;
          remain <= target;
        end
      end else if (tick) begin
        if (remain == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/acc_delay_timer_chk.sv
module acc_delay_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy))); // R8
  AST_BUSY_HOLDS_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R7
  AST_IDLE_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R9
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R7
endmodule

bind acc_delay_timer acc_delay_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
);

// File: tb/sim_acc_delay_timer.sv
module sim_acc_delay_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_in = 1'b0;
  logic start = 1'b0;
  logic align_req = 1'b0;
  logic [2:0] period_code = 3'd0;
  logic fast_rd = 1'b0;
  logic src_dl = 1'b1;
  logic busy, done;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int osc_half = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  acc_delay_timer u0 (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .start(start),
    .align_req(align_req), .period_code(period_code), .fast_rd(fast_rd),
    .src_dl(src_dl), .busy(busy), .done(done)
  );

  // behavioural reference
  bit m_busy, m_done, m_src;
  int m_rem, m_edges;
  bit h1, h2, h3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_src = 0; m_rem = 0; m_edges = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit tk;
      tk = m_src ? ((m_edges % 8) == 7) : (h2 && !h3);
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1;
          m_src  = src_dl;
          m_rem  = align_req ? 1 : (period_code + 1) * (fast_rd ? 2 : 4);
        end
      end else if (tk) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; end
      end
      m_edges = m_edges + 1;
      h3 = h2; h2 = h1; h1 = osc_in;
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (busy !== m_busy || done !== m_done) begin
      miscompares++;
      $display("FAIL %s cycle %0d: busy/done = %b%b expected %b%b",
               cur_req, cycles, busy, done, m_busy, m_done);
    end
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (osc_half > 0) begin
        repeat (osc_half - 1) @(negedge clk);
        osc_in = ~osc_in;
      end
    end
  end

  task automatic run(input bit al, input int code, input bit fr, input bit sel,
                     input int gap, input bit poke);
    int guard;
    repeat (gap) @(negedge clk);
    align_req = al; period_code = 3'(code); fast_rd = fr; src_dl = sel; start = 1;
    @(negedge clk);
    start = poke;
    if (poke) begin
      align_req = ~al; period_code = ~period_code; fast_rd = ~fr; src_dl = ~sel;
    end
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    start = 0;
    vectors++;
    if (!done) begin
      miscompares++;
      $display("FAIL %s no done pulse: done=%b expected 1", cur_req, done);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    cur_req = "R2";
    for (int c = 0; c < 8; c++) run(0, c, 0, 1, c % 5, 0);
    cur_req = "R3";
    for (int c = 0; c < 8; c++) run(0, c, 1, 1, (c * 3) % 7, 0);
    cur_req = "R4";
    for (int g = 0; g < 8; g++) run(1, 7 - g, g[0], 1, g, 0);
    cur_req = "R5";
    osc_half = 3;
    run(0, 1, 0, 0, 1, 0);
    run(0, 2, 1, 0, 2, 0);
    osc_half = 5;
    run(1, 4, 0, 0, 3, 0);
    cur_req = "R6";
    osc_half = 0; osc_in = 1;
    fork
      run(1, 0, 0, 0, 1, 0);
      begin repeat (30) @(negedge clk); osc_in = 0; repeat (4) @(negedge clk); osc_in = 1; end
    join
    osc_in = 0;
    cur_req = "R7";
    for (int g = 0; g < 4; g++) run(0, g, g[1], 1, g, 1);
    osc_half = 2;
    run(0, 3, 0, 0, 2, 1);
    cur_req = "R9";
    for (int g = 0; g < 10; g++) run(g[0], g % 8, g[1], g[2], g, 1);
    osc_half = 0;
    cur_req = "R8";
    run(0, 0, 1, 1, 3, 0);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule